// File: doc/BRIEF.md
# Translation Lookaside Buffer With Walk Fallback

This block caches a few virtual-to-physical translations in front of a page table walker. Each accepted lookup searches every cached entry and also starts a walk in the same cycle. If an entry matches, the answer appears in that cycle and the walk is cancelled. If nothing matches, the block waits for the walker, returns the walker's answer and keeps it for later lookups.

Each entry records its own page size: 4 KB, 2 MB or 1 GB. A larger page compares fewer tag bits and passes more of the address through as offset, so all three sizes share one array. Write and user permission bits are kept with each entry and checked on every hit. The block can also drop every entry at once, or drop only the entries that cover a given address.

Top module: `xlat_cache`

## Requirements
- R1: Every lookup accepted while `req_ready` is high raises `walk_start` in the same cycle.
- R2: On a hit, `resp_valid`, `resp_hit` and `walk_cancel` are high in the request cycle, and `resp_paddr` is the cached frame address with the page offset taken from the virtual address.
- R3: On a miss there is no response in the request cycle, and `req_ready` stays low until `walk_done`. The response comes in the `walk_done` cycle with `resp_hit` low and the walker's translation. A later lookup in the same page hits.
- R4: Page size code 0 means 4 KB (offset is vaddr bits 11:0), code 1 means 2 MB (offset bits 20:0), and code 2 means 1 GB (offset bits 29:0). Any address inside a cached page hits.
- R5: A write to a page without write permission, or a user access to a page without user permission, sets `resp_fault`. On a hit this starts no fill, and the entry stays valid.
- R6: When the walker reports a fault, `resp_fault` is set and the result is not cached, so the next lookup of that page misses again.
- R7: A `flush` pulse invalidates every entry by the next cycle.
- R8: An invalidate removes every entry whose page covers `inval_vaddr`, using that entry's own page size, and leaves all other entries in place.
- R9: Fills go to the entries in round-robin order. Once all entries are full, the next fill replaces the oldest one.
- R10: After reset, `req_ready` is high, no response is pending and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_ready | output | 1 | Block can take a lookup |
| resp_valid | output | 1 | Translation result valid |
| resp_hit | output | 1 | Result came from the cache |
| resp_fault | output | 1 | Permission or walker fault |
| resp_paddr | output | PA_W | Physical address |
| walk_start | output | 1 | Launch a page table walk |
| walk_cancel | output | 1 | Drop the walk just launched |
| walk_done | input | 1 | Walker result valid |
| walk_ppn | input | PA_W-12 | Physical frame number from the walker |
| walk_size | input | 2 | Page size code from the walker |
| walk_write_ok | input | 1 | Page is writable |
| walk_user_ok | input | 1 | Page is user accessible |
| walk_fault | input | 1 | Walk failed |
| flush | input | 1 | Invalidate all entries |
| inval_valid | input | 1 | Invalidate entries covering an address |
| inval_vaddr | input | VA_W | Address to invalidate |

## Verification
Lookups cover three kinds of address. The first kind repeats an address already seen, which separates a hit from a miss. The second lies elsewhere in a 4 KB, 2 MB or 1 GB page already cached, which shows whether the tag mask follows the stored page size and the offset bits pass through. The third differs from a cached address only in the permission it needs, which separates a permission fault on a hit from a walker fault that must not be cached. Sequences of invalidate, flush and more than eight fills then show whether the right entries, and only those, are removed or replaced.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      PG_4K = 2'd0,
      PG_2M = 2'd1,
      PG_1G = 2'd2
   } pg_size_e;

   // number of untranslated low address bits for a size code
   function automatic int unsigned offset_bits(input logic [1:0] sz);
      case (sz)
         2'd1:    return 21;
         2'd2:    return 30;
         default: return 12;
      endcase
   endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match
   import xlat_pkg::*;
#(
   parameter int VPN_W = 36
) (
   input  logic             ent_valid,
   input  logic [VPN_W-1:0] ent_tag,
   input  logic [1:0]       ent_size,
   input  logic [VPN_W-1:0] probe_vpn,
   output logic             match
);
   logic [VPN_W-1:0] care;

   always_comb begin
      care  = {VPN_W{1'b1}} << (offset_bits(ent_size) - 12);
      match = ent_valid && (((ent_tag ^ probe_vpn) & care) == '0);
   end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int ENTRIES = 8,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (advance) ptr <= (ptr == IDX_W'(ENTRIES-1)) ? '0 : ptr + 1'b1;
   end

   AST_PTR_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (ptr == (($past(ptr) == IDX_W'(ENTRIES-1)) ? '0 : $past(ptr) + 1'b1))); // R9
   AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ptr)); // R9
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int VA_W    = 48,
   parameter int PA_W    = 40,
   parameter int ENTRIES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic              req_write,
   input  logic              req_user,
   output logic              req_ready,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic              resp_fault,
   output logic [PA_W-1:0]   resp_paddr,
   output logic              walk_start,
   output logic              walk_cancel,
   input  logic              walk_done,
   input  logic [PA_W-13:0]  walk_ppn,
   input  logic [1:0]        walk_size,
   input  logic              walk_write_ok,
   input  logic              walk_user_ok,
   input  logic              walk_fault,
   input  logic              flush,
   input  logic              inval_valid,
   input  logic [VA_W-1:0]   inval_vaddr
);
   localparam int VPN_W = VA_W - 12;
   localparam int PPN_W = PA_W - 12;
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES)
      $error("ENTRIES must be a power of two of at least 2");
   if (VA_W < 31 || PA_W < 31)
      $error("address widths must cover a 1 GB offset");
   if (PA_W > VA_W)
      $error("PA_W must not exceed VA_W");

   logic [ENTRIES-1:0] vld_q;
   logic [VPN_W-1:0]   tag_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   logic [1:0]         size_q [ENTRIES];
   logic [ENTRIES-1:0] wok_q, uok_q;

   logic               busy_q;
   logic [VA_W-1:0]    va_q;
   logic               wr_q, usr_q;

   logic [ENTRIES-1:0] look_hit, kill_hit;
   logic               hit_any;
   logic [IDX_W-1:0]   hit_idx;
   logic [IDX_W-1:0]   victim;
   logic               accept, fill, install;

   function automatic logic [PA_W-1:0] compose(input logic [PPN_W-1:0] ppn,
                                               input logic [1:0] sz,
                                               input logic [VA_W-1:0] va);
      logic [PA_W-1:0] keep;
      keep = PA_W'((64'd1 << offset_bits(sz)) - 64'd1);
      return ({ppn, 12'h000} & ~keep) | (va[PA_W-1:0] & keep);
   endfunction

   function automatic logic denied(input logic wr, input logic usr,
                                   input logic wok, input logic uok);
      return (wr && !wok) || (usr && !uok);
   endfunction

   // parallel tag compare, one comparator per entry for lookup and invalidate
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      xlat_match #(.VPN_W(VPN_W)) u_look (
         .ent_valid(vld_q[i]), .ent_tag(tag_q[i]), .ent_size(size_q[i]),
         .probe_vpn(req_vaddr[VA_W-1:12]), .match(look_hit[i]));
      xlat_match #(.VPN_W(VPN_W)) u_kill (
         .ent_valid(vld_q[i] && inval_valid), .ent_tag(tag_q[i]), .ent_size(size_q[i]),
         .probe_vpn(inval_vaddr[VA_W-1:12]), .match(kill_hit[i]));
   end

   always_comb begin
      hit_any = 1'b0;
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (look_hit[i]) begin
            hit_any = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
   end

   assign req_ready   = !busy_q;
   assign accept      = req_valid && !busy_q;
   assign walk_start  = accept;
   assign walk_cancel = accept && hit_any;
   assign fill        = busy_q && walk_done && !walk_fault;
   assign install     = fill && !flush;

   always_comb begin
      resp_valid = 1'b0;
      resp_hit   = 1'b0;
      resp_fault = 1'b0;
      resp_paddr = '0;
      if (accept && hit_any) begin
         resp_valid = 1'b1;
         resp_hit   = 1'b1;
         resp_fault = denied(req_write, req_user, wok_q[hit_idx], uok_q[hit_idx]);
         resp_paddr = compose(ppn_q[hit_idx], size_q[hit_idx], req_vaddr);
      end else if (busy_q && walk_done) begin
         resp_valid = 1'b1;
         resp_fault = walk_fault || denied(wr_q, usr_q, walk_write_ok, walk_user_ok);
         resp_paddr = compose(walk_ppn, walk_size, va_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         va_q   <= '0;
         wr_q   <= 1'b0;
         usr_q  <= 1'b0;
      end else if (accept && !hit_any) begin
         busy_q <= 1'b1;
         va_q   <= req_vaddr;
         wr_q   <= req_write;
         usr_q  <= req_user;
      end else if (busy_q && walk_done) begin
         busy_q <= 1'b0;
      end
   end

   xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .advance(install), .ptr(victim));

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic take;
      assign take = install && (victim == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          vld_q[i] <= 1'b0;
         else if (flush)      vld_q[i] <= 1'b0;
         else if (take)       vld_q[i] <= 1'b1;
         else if (kill_hit[i]) vld_q[i] <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (take) begin
            tag_q[i]  <= va_q[VA_W-1:12];
            ppn_q[i]  <= walk_ppn;
            size_q[i] <= walk_size;
            wok_q[i]  <= walk_write_ok;
            uok_q[i]  <= walk_user_ok;
         end
      end
   end

   AST_CANCEL_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      walk_cancel |-> (resp_valid && resp_hit && walk_start)); // R2
   AST_MISS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_start && !walk_cancel) |=> !req_ready); // R3
   AST_WALK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && walk_done) |-> (resp_valid && !resp_hit)); // R3
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0)); // R7
   AST_FAULT_NOT_CACHED: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && walk_done && walk_fault && !flush && !inval_valid)
      |=> (vld_q == $past(vld_q))); // R6
   AST_PERM_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_hit && resp_fault) |=> req_ready); // R5
endmodule

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
   localparam int VA_W = 48;
   localparam int PA_W = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
   logic [VA_W-1:0] req_vaddr = '0;
   logic req_ready, resp_valid, resp_hit, resp_fault, walk_start, walk_cancel;
   logic [PA_W-1:0] resp_paddr;
   logic walk_done = 1'b0, walk_write_ok = 1'b0, walk_user_ok = 1'b0, walk_fault = 1'b0;
   logic [PA_W-13:0] walk_ppn = '0;
   logic [1:0] walk_size = '0;
   logic flush = 1'b0, inval_valid = 1'b0;
   logic [VA_W-1:0] inval_vaddr = '0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   xlat_cache #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(8)) u_xlat_cache (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user), .req_ready(req_ready),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
      .resp_paddr(resp_paddr), .walk_start(walk_start), .walk_cancel(walk_cancel),
      .walk_done(walk_done), .walk_ppn(walk_ppn), .walk_size(walk_size),
      .walk_write_ok(walk_write_ok), .walk_user_ok(walk_user_ok),
      .walk_fault(walk_fault), .flush(flush), .inval_valid(inval_valid),
      .inval_vaddr(inval_vaddr));

   // page table model: byte 5 selects the page size, bits 39/38/37 deny write/user or fail
   function automatic logic [1:0] m_size(input logic [VA_W-1:0] va);
      return (va[47:40] == 8'h01) ? 2'd1 : (va[47:40] == 8'h02) ? 2'd2 : 2'd0;
   endfunction
   function automatic logic [PA_W-13:0] m_ppn(input logic [VA_W-1:0] va);
      return {4'hC, va[35:12]};
   endfunction
   function automatic logic [PA_W-1:0] m_pa(input logic [VA_W-1:0] va);
      logic [PA_W-1:0] low;
      int lb;
      lb  = (m_size(va) == 2'd1) ? 21 : (m_size(va) == 2'd2) ? 30 : 12;
      low = PA_W'((64'd1 << lb) - 64'd1);
      return ({m_ppn(va), 12'h000} & ~low) | (va[PA_W-1:0] & low);
   endfunction
   function automatic logic m_fault(input logic [VA_W-1:0] va, input logic wr,
                                    input logic usr, input logic walked);
      return (walked && va[37]) || (wr && va[39]) || (usr && va[38]);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic lookup(input logic [VA_W-1:0] va, input logic wr, input logic usr,
                         input logic exp_hit, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
      #1;
      check(walk_start == 1'b1, {req, "/R1 walk_start"}, 64'(walk_start), 64'd1);
      if (exp_hit) begin
         check(resp_valid && resp_hit && walk_cancel, {req, "/R2 hit+cancel"},
               64'({resp_valid, resp_hit, walk_cancel}), 64'h7);
         check(resp_fault == m_fault(va, wr, usr, 1'b0), {req, "/R5 fault"},
               64'(resp_fault), 64'(m_fault(va, wr, usr, 1'b0)));
         check(resp_paddr == m_pa(va), {req, "/R4 paddr"}, 64'(resp_paddr), 64'(m_pa(va)));
         @(negedge clk);
         req_valid = 1'b0;
      end else begin
         check(!resp_valid && !walk_cancel, {req, "/R3 no early resp"},
               64'({resp_valid, walk_cancel}), 64'h0);
         @(negedge clk);
         req_valid = 1'b0;
         #1;
         check(req_ready == 1'b0, {req, "/R3 busy"}, 64'(req_ready), 64'd0);
         walk_done = 1'b1; walk_ppn = m_ppn(va); walk_size = m_size(va);
         walk_write_ok = !va[39]; walk_user_ok = !va[38]; walk_fault = va[37];
         #1;
         check(resp_valid && !resp_hit, {req, "/R3 walk resp"},
               64'({resp_valid, resp_hit}), 64'h2);
         check(resp_fault == m_fault(va, wr, usr, 1'b1), {req, "/R6 fault"},
               64'(resp_fault), 64'(m_fault(va, wr, usr, 1'b1)));
         if (!va[37])
            check(resp_paddr == m_pa(va), {req, "/R4 paddr"}, 64'(resp_paddr), 64'(m_pa(va)));
         @(negedge clk);
         walk_done = 1'b0;
      end
   endtask

   typedef struct packed {
      logic [VA_W-1:0] va;
      logic            wr;
      logic            usr;
      logic            hit;
   } vec_t;

   localparam vec_t VEC [14] = '{
      '{48'h0000_0000_1234, 1'b0, 1'b0, 1'b0},
      '{48'h0000_0000_1FFF, 1'b0, 1'b0, 1'b1},
      '{48'h0000_0000_2000, 1'b0, 1'b0, 1'b0},
      '{48'h0100_0000_0010, 1'b0, 1'b0, 1'b0},
      '{48'h0100_001F_FFF8, 1'b0, 1'b0, 1'b1},
      '{48'h0200_1234_5678, 1'b0, 1'b0, 1'b0},
      '{48'h0200_3FFF_0000, 1'b0, 1'b0, 1'b1},
      '{48'h0080_0000_3000, 1'b0, 1'b0, 1'b0},
      '{48'h0080_0000_3000, 1'b1, 1'b0, 1'b1},
      '{48'h0080_0000_3008, 1'b0, 1'b0, 1'b1},
      '{48'h0040_0000_4000, 1'b0, 1'b1, 1'b0},
      '{48'h0040_0000_4000, 1'b0, 1'b0, 1'b1},
      '{48'h0020_0000_5000, 1'b0, 1'b0, 1'b0},
      '{48'h0020_0000_5000, 1'b0, 1'b0, 1'b0}
   };

   initial begin
      repeat (3) @(negedge clk);
      check(req_ready && !resp_valid, "R10 reset state", 64'({req_ready, resp_valid}), 64'h2);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !resp_valid && !walk_start, "R10 idle after reset",
            64'({req_ready, resp_valid, walk_start}), 64'h4);

      // vectors: first lookup misses (R10), size masks (R4), permissions (R5), walker fault (R6)
      for (int i = 0; i < 14; i++)
         lookup(VEC[i].va, VEC[i].wr, VEC[i].usr, VEC[i].hit, $sformatf("vec%0d", i));

      // R8: invalidate inside the 2 MB page removes it, 4 KB entry stays
      @(negedge clk); inval_valid = 1'b1; inval_vaddr = 48'h0100_0000_1000;
      @(negedge clk); inval_valid = 1'b0;
      lookup(48'h0100_0000_0010, 1'b0, 1'b0, 1'b0, "R8 invalidated page");
      lookup(48'h0000_0000_1234, 1'b0, 1'b0, 1'b1, "R8 other page kept");

      // R9: two more fills wrap the round-robin pointer onto the oldest entry
      lookup(48'h0000_0100_0000, 1'b0, 1'b0, 1'b0, "R9 fill 8");
      lookup(48'h0000_0100_1000, 1'b0, 1'b0, 1'b0, "R9 fill 9");
      lookup(48'h0000_0000_1234, 1'b0, 1'b0, 1'b0, "R9 oldest evicted");
      lookup(48'h0200_1234_5678, 1'b0, 1'b0, 1'b1, "R9 middle entry kept");
      lookup(48'h0000_0000_2000, 1'b0, 1'b0, 1'b0, "R9 second oldest evicted");

      // R7: flush drops everything
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      lookup(48'h0200_1234_5678, 1'b0, 1'b0, 1'b0, "R7 flushed 1G");
      lookup(48'h0000_0100_1000, 1'b0, 1'b0, 1'b0, "R7 flushed 4K");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule